// File: doc/BRIEF.md
# Reservation Station Pool with Shared Result Bus

This block holds operations that have been issued but not yet executed, sorted into three classes of reservation stations: integer/load/branch, floating add and floating multiply. Each station keeps two operand values and, for any operand not yet produced, the reorder-buffer tag of the operation that will produce it. A station whose operands are all present runs for its class's fixed latency. Its result then goes out on a single shared result bus, which can carry only one result each cycle.

Every waiting station watches the bus. When the tag on the bus matches one of its pending source tags, it takes the value. An operation being issued in the same cycle as a matching broadcast takes the value straight off the bus. When several finished results compete for the bus, the one with the smallest destination tag (the oldest) goes first and the others wait. Per-class stall outputs tell the issue stage when a class has no free station. Functional units are modelled as latency counters with a simple arithmetic placeholder result.

Top module: `rsPool`

## Requirements
- R1: While reset is held and right after it is released, `busValid` is 0 and all three `stall` bits are 0. Any stations occupied before the reset are emptied.
- R2: Class codes on `issueClass` are 0 = integer/load/branch (3 stations), 1 = floating add (3 stations) and 2 = floating multiply (2 stations). `stall` bit 0/1/2 belongs to class 0/1/2. A bit is 1 exactly when every station of that class is occupied.
- R3: An operation issued with both source tags 0 appears on the bus a fixed number of clock edges after its issue edge, when it meets no competition for the bus. That number is 2 for class 0, 3 for class 1 and 4 for class 2: the execution latency of 1, 2 or 3 cycles, plus one cycle for the bus write.
- R4: The broadcast value is computed modulo 2^16. It is j+k for class 0, j-k for class 1 and the low 16 bits of j*k for class 2. The broadcast tag is the operation's destination tag.
- R5: At most one result is broadcast per cycle. Among results that are ready in the same cycle, the smallest destination tag goes first. A losing result is held and retried in the following cycles.
- R6: A source tag of 0 means the value was supplied at issue. A station with a nonzero source tag waits until that tag is broadcast, then takes the bus value and starts execution. Its own result appears L+2 edges after the edge that put the producer on the bus, where L is its execution latency.
- R7: If an issued operation's source tag equals the tag on the bus in its issue cycle, it takes the bus value in place of the value on the issue port. Its result then appears L+1 edges after its issue edge.
- R8: An issue request to a class whose `stall` bit is 1 is ignored. It never produces a broadcast and leaves the class fully occupied.
- R9: A station is freed in the same edge that puts its result on the bus. The class's `stall` bit is therefore already 0 in the cycle the result is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | Issue request this cycle |
| issueClass | input | 2 | Operation class code |
| issueSrcJVal | input | 16 | First operand value (used when its tag is 0) |
| issueSrcJTag | input | 4 | First operand producer tag, 0 = present |
| issueSrcKVal | input | 16 | Second operand value (used when its tag is 0) |
| issueSrcKTag | input | 4 | Second operand producer tag, 0 = present |
| issueDest | input | 4 | Destination reorder-buffer tag (nonzero) |
| stall | output | 3 | Per-class full indication |
| busValid | output | 1 | Result bus carries a broadcast |
| busTag | output | 4 | Tag of the broadcast result |
| busValue | output | 16 | Value of the broadcast result |

## Verification
Every result is due at a fixed cycle. An operation that is ready at issue is due L+1 edges after its issue edge. A consumer woken by a broadcast, or fed by the bus at issue, is due L+2 edges after the edge that put the producer on the bus. A loser of arbitration is due one edge after the winner. `stall` changes on the issue edge or the broadcast edge itself. The bench keeps an edge counter and logs every broadcast with its edge number, tag, value and the `stall` bits of that cycle, sampling 1 ns after the edge. Each check compares the logged edge number against the count above for that class and case, so a result that arrives one cycle early or late fails just as a wrong value does.

// File: rtl/rsPoolPkg.sv
package rsPoolPkg;
  localparam int DATA_W   = 16;
  localparam int TAG_W    = 4;
  localparam int NUM_CLS  = 3;
  localparam int CLS_W    = 2;
  localparam int INT_CNT  = 3;
  localparam int FADD_CNT = 3;
  localparam int FMUL_CNT = 2;
  localparam int INT_LAT  = 1;
  localparam int FADD_LAT = 2;
  localparam int FMUL_LAT = 3;
  localparam int NUM_RS   = INT_CNT + FADD_CNT + FMUL_CNT;
  localparam int MAX_LAT  = (INT_LAT > FADD_LAT) ? ((INT_LAT > FMUL_LAT) ? INT_LAT : FMUL_LAT)
                                                 : ((FADD_LAT > FMUL_LAT) ? FADD_LAT : FMUL_LAT);
  localparam int CNT_W    = $clog2(MAX_LAT + 1);

  typedef enum logic [CLS_W-1:0] {
    CLS_INT  = 2'd0,
    CLS_FADD = 2'd1,
    CLS_FMUL = 2'd2
  } opClassT;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_RS-1:0] load;
    logic [NUM_RS-1:0] capJ;
    logic [NUM_RS-1:0] capK;
    logic [NUM_RS-1:0] win;
    logic              bypJ;
    logic              bypK;
    logic              winValid;
  } rsStrobeT;

  function automatic opClassT classOf(input int idx);
    if (idx < INT_CNT) return CLS_INT;
    if (idx < INT_CNT + FADD_CNT) return CLS_FADD;
    return CLS_FMUL;
  endfunction

  function automatic int latOf(input opClassT c);
    case (c)
      CLS_INT:  return INT_LAT;
      CLS_FADD: return FADD_LAT;
      default:  return FMUL_LAT;
    endcase
  endfunction

  function automatic logic [NUM_RS-1:0] clsMask(input int c);
    logic [NUM_RS-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (int'(classOf(i)) == c) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/rsPoolCtrl.sv
module rsPoolCtrl
  import rsPoolPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [CLS_W-1:0]   issueClass,
  input  logic [TAG_W-1:0]   issueQj,
  input  logic [TAG_W-1:0]   issueQk,
  input  logic [TAG_W-1:0]   issueDest,
  output logic [NUM_CLS-1:0] stall,
  output rsStrobeT           st,
  output logic               busValid,
  output logic [TAG_W-1:0]   busTag
);
  logic [NUM_RS-1:0] busy;
  logic [TAG_W-1:0]  qj   [NUM_RS];
  logic [TAG_W-1:0]  qk   [NUM_RS];
  logic [TAG_W-1:0]  dest [NUM_RS];
  logic [CNT_W-1:0]  cnt  [NUM_RS];
  logic [NUM_RS-1:0] ready, done;
  logic              classFree;
  logic [TAG_W-1:0]  winTag;

  // per-class occupancy
  always_comb begin
    stall = '1;
    for (int c = 0; c < NUM_CLS; c++) begin
      for (int i = 0; i < NUM_RS; i++) begin
        if (int'(classOf(i)) == c && !busy[i]) stall[c] = 1'b0;
      end
    end
  end

  always_comb begin
    classFree = 1'b0;
    for (int c = 0; c < NUM_CLS; c++) begin
      if (int'(issueClass) == c && !stall[c]) classFree = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_RS; i++) begin
      ready[i] = busy[i] && (qj[i] == '0) && (qk[i] == '0);
      done[i]  = ready[i] && (cnt[i] == '0);
    end
  end

  // station selection, tag matching, oldest-first arbitration
  always_comb begin
    logic found;
    st       = '0;
    winTag   = '0;
    found    = 1'b0;
    st.bypJ  = busValid && (issueQj != '0) && (issueQj == busTag);
    st.bypK  = busValid && (issueQk != '0) && (issueQk == busTag);
    for (int i = 0; i < NUM_RS; i++) begin
      if (issueValid && classFree && !found && !busy[i] &&
          int'(classOf(i)) == int'(issueClass)) begin
        st.load[i] = 1'b1;
        found      = 1'b1;
      end
      st.capJ[i] = busy[i] && busValid && (qj[i] != '0) && (qj[i] == busTag);
      st.capK[i] = busy[i] && busValid && (qk[i] != '0) && (qk[i] == busTag);
    end
    for (int i = 0; i < NUM_RS; i++) begin
      if (done[i] && (!st.winValid || dest[i] < winTag)) begin
        st.win      = '0;
        st.win[i]   = 1'b1;
        st.winValid = 1'b1;
        winTag      = dest[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= '0;
      busValid <= 1'b0;
      busTag   <= '0;
      for (int i = 0; i < NUM_RS; i++) begin
        qj[i]   <= '0;
        qk[i]   <= '0;
        dest[i] <= '0;
        cnt[i]  <= '0;
      end
    end else begin
      busValid <= st.winValid;
      busTag   <= winTag;
      for (int i = 0; i < NUM_RS; i++) begin
        if (st.win[i]) begin
          busy[i] <= 1'b0;
        end else if (st.load[i]) begin
          busy[i] <= 1'b1;
          qj[i]   <= st.bypJ ? '0 : issueQj;
          qk[i]   <= st.bypK ? '0 : issueQk;
          dest[i] <= issueDest;
          cnt[i]  <= CNT_W'(latOf(classOf(i)));
        end else begin
          if (st.capJ[i]) qj[i] <= '0;
          if (st.capK[i]) qk[i] <= '0;
          if (ready[i] && cnt[i] != '0) cnt[i] <= cnt[i] - 1'b1;
        end
      end
    end
  end

  for (genvar i = 0; i < NUM_RS; i++) begin : g_rsChk
    AST_FREE_ON_WIN: assert property (@(posedge clk) disable iff (!rstN)
      st.win[i] |=> !busy[i]); // R9
    AST_CAPTURE_J: assert property (@(posedge clk) disable iff (!rstN)
      st.capJ[i] |=> (qj[i] == '0)); // R6
    AST_CAPTURE_K: assert property (@(posedge clk) disable iff (!rstN)
      st.capK[i] |=> (qk[i] == '0)); // R6
    AST_OLDEST_FIRST: assert property (@(posedge clk) disable iff (!rstN)
      (done[i] && !st.win[i]) |-> (st.winValid && dest[i] > winTag)); // R5
    AST_LOSER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (done[i] && !st.win[i]) |=> done[i]); // R5
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_clsChk
    localparam logic [NUM_RS-1:0] MASK = clsMask(c);
    AST_STALL_NO_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
      stall[c] |=> ($countones(busy & MASK) <= $past($countones(busy & MASK)))); // R8
  end
endmodule

// File: rtl/rsPoolData.sv
module rsPoolData
  import rsPoolPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobeT          st,
  input  logic [DATA_W-1:0] issueVj,
  input  logic [DATA_W-1:0] issueVk,
  output logic [DATA_W-1:0] busValue
);
  logic [DATA_W-1:0] vj [NUM_RS];
  logic [DATA_W-1:0] vk [NUM_RS];
  logic [DATA_W-1:0] result;

  function automatic logic [DATA_W-1:0] calc(input opClassT c,
                                             input logic [DATA_W-1:0] a,
                                             input logic [DATA_W-1:0] b);
    case (c)
      CLS_INT:  return a + b;
      CLS_FADD: return a - b;
      default:  return a * b;
    endcase
  endfunction

  always_comb begin
    result = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (st.win[i]) result = calc(classOf(i), vj[i], vk[i]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busValue <= '0;
      for (int i = 0; i < NUM_RS; i++) begin
        vj[i] <= '0;
        vk[i] <= '0;
      end
    end else begin
      if (st.winValid) busValue <= result;
      for (int i = 0; i < NUM_RS; i++) begin
        if (st.load[i]) begin
          vj[i] <= st.bypJ ? busValue : issueVj;
          vk[i] <= st.bypK ? busValue : issueVk;
        end else begin
          if (st.capJ[i]) vj[i] <= busValue;
          if (st.capK[i]) vk[i] <= busValue;
        end
      end
    end
  end

  AST_VALUE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !st.winValid |=> $stable(busValue)); // R4
endmodule

// File: rtl/rsPool.sv
module rsPool
  import rsPoolPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               issueValid,
  input  logic [CLS_W-1:0]   issueClass,
  input  logic [DATA_W-1:0]  issueSrcJVal,
  input  logic [TAG_W-1:0]   issueSrcJTag,
  input  logic [DATA_W-1:0]  issueSrcKVal,
  input  logic [TAG_W-1:0]   issueSrcKTag,
  input  logic [TAG_W-1:0]   issueDest,
  output logic [NUM_CLS-1:0] stall,
  output logic               busValid,
  output logic [TAG_W-1:0]   busTag,
  output logic [DATA_W-1:0]  busValue
);
  rsStrobeT strobe;

  rsPoolCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .issueValid(issueValid),
    .issueClass(issueClass),
    .issueQj   (issueSrcJTag),
    .issueQk   (issueSrcKTag),
    .issueDest (issueDest),
    .stall     (stall),
    .st        (strobe),
    .busValid  (busValid),
    .busTag    (busTag)
  );

  rsPoolData u_data (
    .clk     (clk),
    .rstN    (rstN),
    .st      (strobe),
    .issueVj (issueSrcJVal),
    .issueVk (issueSrcKVal),
    .busValue(busValue)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> !busValid); // R1
endmodule

// File: tb/rsPool_test.sv
module rsPool_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [1:0]  issueClass = '0;
  logic [15:0] jVal = '0, kVal = '0;
  logic [3:0]  jTag = '0, kTag = '0, dest = '0;
  logic [2:0]  stall;
  logic        busValid;
  logic [3:0]  busTag;
  logic [15:0] busValue;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int          logCyc   [256];
  logic [3:0]  logTag   [256];
  logic [15:0] logVal   [256];
  logic [2:0]  logStall [256];
  int          logN = 0;

  rsPool uut (
    .clk(clk), .rstN(rstN), .issueValid(issueValid), .issueClass(issueClass),
    .issueSrcJVal(jVal), .issueSrcJTag(jTag), .issueSrcKVal(kVal), .issueSrcKTag(kTag),
    .issueDest(dest), .stall(stall), .busValid(busValid), .busTag(busTag), .busValue(busValue)
  );

  always #4 clk = ~clk;  // 125 MHz

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    if (busValid === 1'b1 && logN < 256) begin
      logCyc[logN]   = cyc;
      logTag[logN]   = busTag;
      logVal[logN]   = busValue;
      logStall[logN] = stall;
      logN = logN + 1;
    end
  end

  // {class, j, k, expected}
  localparam logic [49:0] VEC [6] = '{
    {2'd0, 16'd7,     16'd9,     16'd16},
    {2'd0, 16'hFFFF,  16'd2,     16'd1},
    {2'd1, 16'd20,    16'd5,     16'd15},
    {2'd1, 16'd3,     16'd5,     16'hFFFE},
    {2'd2, 16'd300,   16'd300,   16'd24464},
    {2'd2, 16'h0100,  16'h0100,  16'd0}
  };

  function automatic int benchLat(input int c);
    case (c)
      0: return 1;
      1: return 2;
      default: return 3;
    endcase
  endfunction

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input int c, input int jv, input int jt, input int kv,
                       input int kt, input int d, output int edgeNo);
    issueClass = 2'(c);
    jVal = 16'(jv); jTag = 4'(jt);
    kVal = 16'(kv); kTag = 4'(kt);
    dest = 4'(d);
    issueValid = 1'b1;
    tick();
    issueValid = 1'b0;
    edgeNo = cyc;
  endtask

  function automatic int findTag(input int tag, input int from);
    for (int i = from; i < logN; i++) begin
      if (int'(logTag[i]) == tag) return i;
    end
    return -1;
  endfunction

  task automatic expectResult(input string req, input int from, input int tag,
                              input int expCyc, input int expVal);
    int idx;
    idx = findTag(tag, from);
    if (idx < 0) begin
      check(1'b0, {req, " result missing, tag"}, -1, tag);
    end else begin
      check(logCyc[idx] == expCyc, {req, " result cycle"}, logCyc[idx], expCyc);
      check(int'(logVal[idx]) == expVal, {req, " result value"}, int'(logVal[idx]), expVal);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0;
    tick();
    check(busValid == 1'b0, "R1 busValid in reset", int'(busValid), 0);
    check(stall == 3'b000, "R1 stall in reset", int'(stall), 0);
    tick();
    rstN = 1'b1;
    tick();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e0, e1, from;
    logic [1:0]  vc;
    logic [15:0] va, vb, ve;

    // R1: reset state
    tick();
    check(busValid == 1'b0, "R1 busValid in reset", int'(busValid), 0);
    tick();
    rstN = 1'b1;
    tick();
    check(busValid == 1'b0, "R1 busValid after reset", int'(busValid), 0);
    check(stall == 3'b000, "R1 stall after reset", int'(stall), 0);

    // R3 / R4: vector table, each op alone
    for (int i = 0; i < 6; i++) begin
      {vc, va, vb, ve} = VEC[i];
      from = logN;
      issue(int'(vc), int'(va), 0, int'(vb), 0, i + 1, e0);
      repeat (6) tick();
      expectResult("R3/R4", from, i + 1, e0 + benchLat(int'(vc)) + 1, int'(ve));
    end

    // R5: two ready in same cycle, smaller tag first
    from = logN;
    issue(1, 20, 0, 3, 0, 7, e0);
    issue(0, 1, 0, 1, 0, 3, e1);
    repeat (6) tick();
    expectResult("R5 winner", from, 3, e0 + 3, 2);
    expectResult("R5 loser retry", from, 7, e0 + 4, 17);

    from = logN;
    issue(1, 9, 0, 4, 0, 2, e0);
    issue(0, 2, 0, 2, 0, 9, e1);
    repeat (6) tick();
    expectResult("R5 winner", from, 2, e0 + 3, 5);
    expectResult("R5 loser retry", from, 9, e0 + 4, 4);

    // R6: waiting operand captured from the bus (J and K)
    from = logN;
    issue(0, 10, 0, 5, 0, 4, e0);               // bus at e0+2
    issue(2, 16'h5555, 4, 3, 0, 6, e1);         // waits on J
    issue(1, 100, 0, 16'h7777, 4, 5, e1);       // waits on K
    repeat (10) tick();
    expectResult("R6 producer", from, 4, e0 + 2, 15);
    expectResult("R6 capture J", from, 6, e0 + 2 + 3 + 2, 45);
    expectResult("R6 capture K", from, 5, e0 + 2 + 2 + 2, 85);

    // R7: issue in the broadcast cycle takes the bus value
    from = logN;
    issue(0, 10, 0, 5, 0, 4, e0);
    tick();
    tick();
    check(busValid == 1'b1 && busTag == 4'd4, "R7 producer on bus", int'(busTag), 4);
    issue(1, 16'h1234, 4, 1, 0, 8, e1);
    repeat (6) tick();
    check(e1 == e0 + 3, "R7 issue edge", e1, e0 + 3);
    expectResult("R7 bypass", from, 8, e1 + 3, 14);

    // R2 / R8: class 0 and class 1 fill up with waiting ops (tag 15 never broadcast)
    doReset();
    issue(0, 0, 15, 0, 0, 1, e0);
    issue(0, 0, 15, 0, 0, 2, e0);
    check(stall == 3'b000, "R2 int two busy no stall", int'(stall), 0);
    issue(0, 0, 15, 0, 0, 3, e0);
    check(stall == 3'b001, "R2 int full", int'(stall), 1);
    from = logN;
    issue(0, 5, 0, 5, 0, 4, e0);
    repeat (6) tick();
    check(findTag(4, from) < 0, "R8 int ignored while stalled", findTag(4, from), -1);
    check(stall == 3'b001, "R8 int still full", int'(stall), 1);
    issue(1, 0, 15, 0, 0, 5, e0);
    issue(1, 0, 15, 0, 0, 6, e0);
    issue(1, 0, 15, 0, 0, 7, e0);
    check(stall == 3'b011, "R2 fadd full", int'(stall), 3);
    doReset();
    check(stall == 3'b000, "R1 reset empties stations", int'(stall), 0);

    // R2 / R8 / R9: multiply class with 2 stations
    from = logN;
    issue(2, 2, 0, 3, 0, 1, e0);
    issue(2, 4, 0, 5, 0, 2, e1);
    check(stall == 3'b100, "R2 fmul full", int'(stall), 4);
    issue(2, 7, 0, 7, 0, 3, e1);
    repeat (8) tick();
    expectResult("R9 first fmul", from, 1, e0 + 4, 6);
    expectResult("R9 second fmul", from, 2, e0 + 5, 20);
    if (findTag(1, from) >= 0)
      check(logStall[findTag(1, from)][2] == 1'b0, "R9 stall freed with broadcast",
            int'(logStall[findTag(1, from)][2]), 0);
    check(findTag(3, from) < 0, "R8 fmul ignored while stalled", findTag(3, from), -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule